// File: doc/BRIEF.md
# Postfix Stack Expression Evaluator

This block evaluates arithmetic expressions written in postfix order. A producer streams tokens over a valid/ready handshake. Each token is tagged as a number, an operator or an end marker. Numbers are pushed onto an internal evaluation stack. An operator pops the two topmost entries and pushes the value it computes: the deeper entry is the left operand and the top entry is the right one. Addition and subtraction finish in the cycle the token is accepted. Multiplication and division go through a shared iterative unit that takes one step per data bit, and input ready stays low while that unit works.

When the end marker arrives, the block reports the expression through a one-cycle pulse. It raises either a result-valid strobe carrying the single value left on the stack, or exactly one error flag. Errors are stack underflow, stack overflow, division by zero and a malformed ending (the stack does not hold exactly one entry). After the first error, every later token of that expression up to its end marker is dropped. Every end marker empties the stack, so the next expression starts clean.

Top module: `rpn_eval`

## Requirements
- R1: Token kind encoding is 0 = number, 1 = operator, 2 = end marker. A number is pushed onto the stack. Kind 3 is reserved and the block discards it without any effect on the stack.
- R2: Operator code 0 adds and code 1 subtracts, deeper entry minus top entry. Both give the 16-bit two's complement result wrapped modulo 2^16.
- R3: Operator code 2 multiplies and returns the low 16 bits of the signed product.
- R4: Operator code 3 divides, deeper entry by top entry, and truncates toward zero. The quotient -32768 / -1 wraps to -32768.
- R5: While a multiply or divide is in progress, tok_ready is low. An add or subtract leaves tok_ready high in the following cycle.
- R6: In the cycle after an end marker is accepted, exactly one report appears. It is res_valid with the stack's only entry, or a single error flag. No report appears at any other time.
- R7: An operator accepted while the stack holds fewer than two entries raises err_underflow at the end marker.
- R8: Up to DEPTH entries can be held. A number arriving when DEPTH entries are held raises err_overflow.
- R9: A division whose divisor is zero raises err_divzero and aborts the expression.
- R10: An end marker with zero entries or more than one entry on the stack, and no earlier error, raises err_malformed.
- R11: After an error, the remaining tokens of that expression are discarded. Only the first error is reported, and the next expression evaluates normally.
- R12: Synchronous reset empties the stack and clears all outputs. tok_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token can be accepted this cycle |
| tok_kind | input | 2 | 0 number, 1 operator, 2 end, 3 reserved |
| tok_op | input | 2 | 0 add, 1 sub, 2 mul, 3 div |
| tok_data | input | DATA_W | Signed number value |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | Expression value |
| err_underflow | output | 1 | Report: too few operands |
| err_overflow | output | 1 | Report: stack full on push |
| err_divzero | output | 1 | Report: zero divisor |
| err_malformed | output | 1 | Report: stack count not one at end |

## Verification
The bound checker watches, on every cycle, the structural rules. These are: ready stays low while the iterative unit is busy, at most one report is active at a time, reports come only in the cycle after an accepted end marker, the stack count never exceeds its depth, and the stack is empty whenever a report appears. The arithmetic itself can only be shown by the bench's scenarios. A sweep over all pairs of a set of edge values runs every operator and compares against arithmetic done in the bench. Directed streams cover the nested example that must give 6, filling to exactly the depth, each error class, and recovery after an abort.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

    typedef enum logic [1:0] {
        K_NUM  = 2'd0,
        K_OPR  = 2'd1,
        K_END  = 2'd2,
        K_RSV  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_e;

    typedef enum logic {
        ST_TAKE = 1'b0,
        ST_WAIT = 1'b1
    } ctl_state_e;

    // bit positions of the error vector
    localparam int unsigned E_UF = 3;
    localparam int unsigned E_OF = 2;
    localparam int unsigned E_DZ = 1;
    localparam int unsigned E_MF = 0;

endpackage

// File: rtl/rpn_stack_mem.sv
module rpn_stack_mem #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_top,
    input  logic [AW-1:0]     raddr_nxt,
    output logic [DATA_W-1:0] rdata_top,
    output logic [DATA_W-1:0] rdata_nxt
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slot_q[waddr] <= wdata;
        end
    end

    assign rdata_top = slot_q[raddr_top];
    assign rdata_nxt = slot_q[raddr_nxt];

endmodule

// File: rtl/rpn_addsub.sv
module rpn_addsub #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              sub,
    output logic [DATA_W-1:0] sum
);

    always_comb begin
        if (sub) begin
            sum = lhs - rhs;
        end else begin
            sum = lhs + rhs;
        end
    end

endmodule

// File: rtl/rpn_muldiv.sv
module rpn_muldiv #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned IW    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_div,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              is_div;
        logic              neg;
        logic [IW-1:0]     iter;
        logic [DATA_W-1:0] acc;   // product or quotient
        logic [DATA_W-1:0] ma;    // multiplicand or dividend shifter
        logic [DATA_W-1:0] mb;    // multiplier or divisor
        logic [DATA_W-1:0] rem;
    } md_t;

    md_t q, d;
    logic [DATA_W:0] rem_ext;
    logic [DATA_W:0] rem_sub;

    function automatic logic [DATA_W-1:0] mag(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        rem_ext = '0;
        rem_sub = '0;
        if (q.busy) begin
            if (!q.is_div) begin
                if (q.mb[0]) begin
                    d.acc = q.acc + q.ma;
                end
                d.ma = q.ma << 1;
                d.mb = q.mb >> 1;
            end else begin
                rem_ext = {q.rem, q.ma[DATA_W-1]};
                rem_sub = rem_ext - {1'b0, q.mb};
                d.ma    = q.ma << 1;
                if (rem_ext >= {1'b0, q.mb}) begin
                    d.rem = rem_sub[DATA_W-1:0];
                    d.acc = {q.acc[DATA_W-2:0], 1'b1};
                end else begin
                    d.rem = rem_ext[DATA_W-1:0];
                    d.acc = {q.acc[DATA_W-2:0], 1'b0};
                end
            end
            d.iter = q.iter - 1'b1;
            if (q.iter == IW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end else if (start) begin
            d.busy   = 1'b1;
            d.is_div = is_div;
            d.iter   = IW'(DATA_W);
            d.acc    = '0;
            d.rem    = '0;
            if (is_div) begin
                d.ma  = mag(lhs);
                d.mb  = mag(rhs);
                d.neg = lhs[DATA_W-1] ^ rhs[DATA_W-1];
            end else begin
                d.ma  = lhs;
                d.mb  = rhs;
                d.neg = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign result = (q.is_div && q.neg) ? (~q.acc + 1'b1) : q.acc;

endmodule

// File: rtl/rpn_eval.sv
module rpn_eval #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_valid,
    output logic              tok_ready,
    input  logic [1:0]        tok_kind,
    input  logic [1:0]        tok_op,
    input  logic [DATA_W-1:0] tok_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              err_underflow,
    output logic              err_overflow,
    output logic              err_divzero,
    output logic              err_malformed
);
    import rpn_pkg::*;

    typedef struct packed {
        ctl_state_e        st;
        logic [CW-1:0]     cnt;
        logic [3:0]        err;
        logic              out_vld;
        logic [DATA_W-1:0] out_data;
        logic [3:0]        out_err;
    } ctl_t;

    ctl_t q, d;

    logic              we;
    logic [AW-1:0]     waddr;
    logic [DATA_W-1:0] wdata;
    logic [AW-1:0]     ra_top, ra_nxt;
    logic [DATA_W-1:0] rd_top, rd_nxt;
    logic [DATA_W-1:0] as_sum;
    logic              md_start, md_busy, md_done;
    logic [DATA_W-1:0] md_res;
    logic [CW-1:0]     stk_cnt;
    logic              take;

    assign ra_top  = AW'(q.cnt - CW'(1));
    assign ra_nxt  = AW'(q.cnt - CW'(2));
    assign stk_cnt = q.cnt;

    rpn_stack_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr_top (ra_top),
        .raddr_nxt (ra_nxt),
        .rdata_top (rd_top),
        .rdata_nxt (rd_nxt)
    );

    rpn_addsub #(.DATA_W(DATA_W)) u_addsub (
        .lhs (rd_nxt),
        .rhs (rd_top),
        .sub (tok_op == OP_SUB),
        .sum (as_sum)
    );

    rpn_muldiv #(.DATA_W(DATA_W)) u_muldiv (
        .clk    (clk),
        .rst    (rst),
        .start  (md_start),
        .is_div (tok_op == OP_DIV),
        .lhs    (rd_nxt),
        .rhs    (rd_top),
        .busy   (md_busy),
        .done   (md_done),
        .result (md_res)
    );

    assign tok_ready = (q.st == ST_TAKE);
    assign take      = tok_valid && tok_ready;

    always_comb begin
        d          = q;
        d.out_vld  = 1'b0;
        d.out_err  = '0;
        we         = 1'b0;
        waddr      = AW'(q.cnt);
        wdata      = tok_data;
        md_start   = 1'b0;
        unique case (q.st)
            ST_TAKE: begin
                if (take) begin
                    unique case (tok_kind_e'(tok_kind))
                        K_END: begin
                            if (q.err != '0) begin
                                d.out_err = q.err;
                            end else if (q.cnt == CW'(1)) begin
                                d.out_vld  = 1'b1;
                                d.out_data = rd_top;
                            end else begin
                                d.out_err[E_MF] = 1'b1;
                            end
                            d.cnt = '0;
                            d.err = '0;
                        end
                        K_NUM: begin
                            if (q.err == '0) begin
                                if (q.cnt == CW'(DEPTH)) begin
                                    d.err[E_OF] = 1'b1;
                                end else begin
                                    we    = 1'b1;
                                    d.cnt = q.cnt + 1'b1;
                                end
                            end
                        end
                        K_OPR: begin
                            if (q.err == '0) begin
                                if (q.cnt < CW'(2)) begin
                                    d.err[E_UF] = 1'b1;
                                end else if (tok_op == OP_ADD || tok_op == OP_SUB) begin
                                    we    = 1'b1;
                                    waddr = ra_nxt;
                                    wdata = as_sum;
                                    d.cnt = q.cnt - 1'b1;
                                end else if (tok_op == OP_DIV && rd_top == '0) begin
                                    d.err[E_DZ] = 1'b1;
                                end else begin
                                    md_start = 1'b1;
                                    d.st     = ST_WAIT;
                                end
                            end
                        end
                        default: begin
                        end
                    endcase
                end
            end
            ST_WAIT: begin
                if (md_done) begin
                    we    = 1'b1;
                    waddr = ra_nxt;
                    wdata = md_res;
                    d.cnt = q.cnt - 1'b1;
                    d.st  = ST_TAKE;
                end
            end
            default: d.st = ST_TAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st       <= ST_TAKE;
            q.cnt      <= '0;
            q.err      <= '0;
            q.out_vld  <= 1'b0;
            q.out_data <= '0;
            q.out_err  <= '0;
        end else begin
            q <= d;
        end
    end

    assign res_valid     = q.out_vld;
    assign res_data      = q.out_data;
    assign err_underflow = q.out_err[E_UF];
    assign err_overflow  = q.out_err[E_OF];
    assign err_divzero   = q.out_err[E_DZ];
    assign err_malformed = q.out_err[E_MF];

endmodule

// File: rtl/rpn_eval_chk.sv
module rpn_eval_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          tok_valid,
    input logic          tok_ready,
    input logic [1:0]    tok_kind,
    input logic          res_valid,
    input logic          err_underflow,
    input logic          err_overflow,
    input logic          err_divzero,
    input logic          err_malformed,
    input logic          md_busy,
    input logic [CW-1:0] stk_cnt
);

    logic [3:0] errs;
    logic       report;
    logic       end_take;

    assign errs     = {err_underflow, err_overflow, err_divzero, err_malformed};
    assign report   = res_valid || (errs != '0);
    assign end_take = tok_valid && tok_ready && (tok_kind == 2'd2);

    // R5
    busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        md_busy |-> !tok_ready);

    // R11
    single_report_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, errs}));

    // R6
    report_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
        end_take |=> report);

    // R6
    no_stray_report_chk: assert property (@(posedge clk) disable iff (rst)
        report |-> $past(end_take));

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stk_cnt <= CW'(DEPTH));

    // R11
    empty_at_report_chk: assert property (@(posedge clk) disable iff (rst)
        report |-> (stk_cnt == '0));

    // R12
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stk_cnt == '0 && !report && tok_ready));

endmodule

bind rpn_eval rpn_eval_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tok_valid     (tok_valid),
    .tok_ready     (tok_ready),
    .tok_kind      (tok_kind),
    .res_valid     (res_valid),
    .err_underflow (err_underflow),
    .err_overflow  (err_overflow),
    .err_divzero   (err_divzero),
    .err_malformed (err_malformed),
    .md_busy       (md_busy),
    .stk_cnt       (stk_cnt)
);

// File: tb/tb_rpn_eval.sv
module tb_rpn_eval;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int DEPTH      = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tok_valid = 1'b0;
    logic         tok_ready;
    logic [1:0]   tok_kind = '0;
    logic [1:0]   tok_op = '0;
    logic [W-1:0] tok_data = '0;
    logic         res_valid;
    logic [W-1:0] res_data;
    logic         err_underflow, err_overflow, err_divzero, err_malformed;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic         got_v;
    logic [W-1:0] got_d;
    logic [3:0]   got_e;   // {underflow, overflow, divzero, malformed}

    rpn_eval #(.DATA_W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_kind(tok_kind), .tok_op(tok_op), .tok_data(tok_data),
        .res_valid(res_valid), .res_data(res_data),
        .err_underflow(err_underflow), .err_overflow(err_overflow),
        .err_divzero(err_divzero), .err_malformed(err_malformed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [1:0] o, input logic [W-1:0] v);
        @(negedge clk);
        tok_valid = 1'b1;
        tok_kind  = k;
        tok_op    = o;
        tok_data  = v;
        while (!tok_ready) @(negedge clk);
        @(posedge clk);
        #1 tok_valid = 1'b0;
    endtask

    task automatic num(input int v);
        send(2'd0, 2'd0, W'(v));
    endtask

    task automatic opr(input logic [1:0] o);
        send(2'd1, o, '0);
    endtask

    task automatic finish_expr();
        send(2'd2, 2'd0, '0);
        @(negedge clk);
        got_v = res_valid;
        got_d = res_data;
        got_e = {err_underflow, err_overflow, err_divzero, err_malformed};
    endtask

    task automatic expect_val(input string tag, input int exp);
        chk(got_v && got_e == 4'd0 && got_d == W'(exp), tag, int'($signed(got_d)), exp);
    endtask

    task automatic expect_err(input string tag, input logic [3:0] e);
        chk(!got_v && got_e == e, tag, {got_v, got_e}, {1'b0, e});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R5 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int vals [12] = '{0, 1, -1, 2, -2, 7, -7, 100, -300, 32767, -32768, 255};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(tok_ready && !res_valid && !err_underflow && !err_overflow && !err_divzero && !err_malformed,
            "R12 reset outputs", {tok_ready, res_valid}, 2);
        finish_expr();
        expect_err("R12 stack empty after reset (R10 malformed)", 4'b0001);

        // R2 R3 R4 R9 sweep over all pairs and operators
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                for (int o = 0; o < 4; o++) begin
                    int a, b, e;
                    a = vals[i];
                    b = vals[j];
                    num(a);
                    num(b);
                    opr(2'(o));
                    finish_expr();
                    if (o == 0) begin
                        e = a + b; expect_val("R2 add", int'($signed(W'(e))));
                    end else if (o == 1) begin
                        e = a - b; expect_val("R2 sub", int'($signed(W'(e))));
                    end else if (o == 2) begin
                        e = a * b; expect_val("R3 mul", int'($signed(W'(e))));
                    end else if (b == 0) begin
                        expect_err("R9 divide by zero", 4'b0010);
                    end else begin
                        e = a / b; expect_val("R4 div", int'($signed(W'(e))));
                    end
                end
            end
        end

        // R1 nested example: 8 2 5 * + 1 3 2 * + 4 - /  = 6
        num(8); num(2); num(5); opr(2); opr(0);
        num(1); num(3); num(2); opr(2); opr(0);
        num(4); opr(1); opr(3);
        finish_expr();
        expect_val("R1 nested expression", 6);

        // R1 reserved kind ignored
        num(5); send(2'd3, 2'd0, 16'd99);
        finish_expr();
        expect_val("R1 reserved kind ignored", 5);

        // R5 ready low during multiply, high after add
        num(6); num(7); opr(2);
        @(negedge clk);
        chk(!tok_ready, "R5 ready low while multiplying", tok_ready, 0);
        num(1); opr(0);
        @(negedge clk);
        chk(tok_ready, "R5 ready high after add", tok_ready, 1);
        finish_expr();
        expect_val("R5 result after stall", 43);

        // R8 exactly full, then overflow
        for (int k = 0; k < DEPTH; k++) num(k + 1);
        for (int k = 0; k < DEPTH - 1; k++) opr(0);
        finish_expr();
        expect_val("R8 full stack reduces", DEPTH * (DEPTH + 1) / 2);
        for (int k = 0; k < DEPTH + 1; k++) num(1);
        finish_expr();
        expect_err("R8 overflow", 4'b0100);

        // R7 underflow
        num(5); opr(0);
        finish_expr();
        expect_err("R7 underflow one entry", 4'b1000);
        opr(1);
        finish_expr();
        expect_err("R7 underflow empty", 4'b1000);

        // R10 malformed
        num(1); num(2);
        finish_expr();
        expect_err("R10 two entries left", 4'b0001);

        // R11 abort discards rest, first error only, clean restart
        num(4); num(0); opr(3); num(9); opr(0); opr(0);
        finish_expr();
        expect_err("R11 divzero then ignored tokens", 4'b0010);
        opr(0); num(2); num(3);
        finish_expr();
        expect_err("R11 underflow then pushes ignored", 4'b1000);
        num(3); num(4); opr(1);
        finish_expr();
        expect_val("R11 clean restart, R2 order", -1);
        num(-7); num(2); opr(3);
        finish_expr();
        expect_val("R4 order and truncation", -3);

        // R6 no report without end marker
        num(1);
        repeat (3) @(negedge clk);
        chk(!res_valid && !err_malformed, "R6 no report mid-expression", res_valid, 0);
        finish_expr();
        expect_val("R6 report after end", 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule